// File: doc/BRIEF.md
# Calendar Time Counter

This block keeps wall-clock calendar time: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-second tick from outside advances it. Each step carries through the fields and follows the length of each month. February has 29 days in leap years. The year field is an offset from 0 to 99 and wraps back to 0.

Software reads and writes each field over a simple register bus, and an unlock input must be high for any write to take effect. A control bit freezes the counter while a new time is loaded. Clearing the bit lets counting resume from the loaded value.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the fields read year 0, month 1, day of month 1, weekday 0, 00:00:00, and the freeze bit reads 0.
- R2: Field registers sit at byte address 0x40 + 4*k, where k = 0 is year, 1 is month, 2 is day of month, 3 is weekday, 4 is hour, 5 is minute and 6 is second. The freeze control is bit 0 at address 0x20. Reads of any other address return 0, and reads are combinational on the address.
- R3: Each accepted tick adds one to the seconds. The second and minute wrap 59 to 0 and carry into the next field, and the hour wraps 23 to 0. Without a tick or a write, no field changes.
- R4: Each midnight carry advances both the day of month and the weekday. The weekday counts 0 to 6 and wraps to 0.
- R5: The day of month wraps to 1 and carries into the month after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R6: February ends after day 29 when the year is a non-zero multiple of 4. Otherwise it ends after day 28, and year 0 also counts as a non-leap year.
- R7: The month counts 1 to 12. A carry out of month 12 sets the month to 1 and adds one to the year, and year 99 rolls over to 0.
- R8: While the freeze bit is 1, ticks change no field. After the bit is cleared, the next tick advances the time again.
- R9: A bus write with unlock high loads the addressed field on the next clock edge. Only the low bits of the write data are kept: 7 for year, 4 for month, 5 for day of month and for hour, 3 for weekday, 6 for minute and for second. A write with unlock low changes nothing.
- R10: A tick in the same cycle as a seconds write is ignored. The seconds take the written value and the minute does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| unlock_i | input | 1 | Write enable qualifier; writes are dropped when low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Bus byte address for reads and writes |
| wdata_i | input | DATA_W | Bus write data |
| rdata_o | output | DATA_W | Read data for addr_i |

## Verification
A wrong month length, leap decision or carry stays hidden until the time reaches a boundary. It then shows as a wrong field readback one tick after the rollover. The bench therefore loads times one second before each boundary and reads every field after a single tick, so such a fault shows up within a few cycles. A broken freeze or unlock shows up as a field that moved when it should have held, and the bench reads that field right after the ignored tick or write.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FLD_W   = 7;
  localparam int NUM_FLD = 7;

  localparam int IX_YEAR  = 0;
  localparam int IX_MONTH = 1;
  localparam int IX_MDAY  = 2;
  localparam int IX_WDAY  = 3;
  localparam int IX_HOUR  = 4;
  localparam int IX_MIN   = 5;
  localparam int IX_SEC   = 6;

  typedef logic [FLD_W-1:0] fld_t;
  typedef fld_t [NUM_FLD-1:0] fld_vec_t;

  // stored bit count for each field
  function automatic int fld_bits(input int idx);
    case (idx)
      IX_YEAR:  return 7;
      IX_MONTH: return 4;
      IX_MDAY:  return 5;
      IX_WDAY:  return 3;
      IX_HOUR:  return 5;
      default:  return 6;
    endcase
  endfunction

  // first value after wrap, also the reset value
  function automatic fld_t fld_lo(input int idx);
    if (idx == IX_MONTH || idx == IX_MDAY) return fld_t'(1);
    return fld_t'(0);
  endfunction

  // fixed last value before wrap (day of month is variable)
  function automatic fld_t fld_hi(input int idx, input int year_top);
    case (idx)
      IX_YEAR:  return fld_t'(year_top);
      IX_MONTH: return fld_t'(12);
      IX_MDAY:  return fld_t'(31);
      IX_WDAY:  return fld_t'(6);
      IX_HOUR:  return fld_t'(23);
      default:  return fld_t'(59);
    endcase
  endfunction
endpackage

// File: rtl/cal_wrap_cnt.sv
module cal_wrap_cnt #(
  parameter int W = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] q_o,
  output logic         wrap_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         q_en;
  logic         at_top;

  assign at_top = (q_q >= hi_i);

  always_comb begin
    q_d    = q_q;
    q_en   = 1'b0;
    wrap_o = 1'b0;
    if (ld_i) begin
      q_d  = ld_val_i;
      q_en = 1'b1;
    end else if (inc_i) begin
      q_en   = 1'b1;
      wrap_o = at_top;
      q_d    = at_top ? lo_i : q_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= RST_VAL;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
  parameter int W = 7
) (
  input  logic [W-1:0] month_i,
  input  logic [W-1:0] year_i,
  output logic [W-1:0] days_o
);
  logic leap;

  // zero year is excluded from the multiple-of-four rule
  assign leap = (year_i[1:0] == 2'b00) && (year_i != '0);

  always_comb begin
    if (month_i == W'(2)) begin
      days_o = leap ? W'(29) : W'(28);
    end else if (month_i == W'(4) || month_i == W'(6) ||
                 month_i == W'(9) || month_i == W'(11)) begin
      days_o = W'(30);
    end else begin
      days_o = W'(31);
    end
  end
endmodule

// File: rtl/cal_bus_regs.sv
module cal_bus_regs
  import cal_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int FIELD_BASE   = 'h40,
  parameter int FIELD_STRIDE = 4,
  parameter int CTRL_ADDR    = 'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unlock_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  fld_vec_t            fld_i,
  output logic [NUM_FLD-1:0]  ld_o,
  output fld_vec_t            ld_val_o,
  output logic                stop_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic               wr_ok;
  logic [NUM_FLD-1:0] hit;
  logic               ctrl_hit;
  logic               stop_q;
  logic               stop_d;
  logic               stop_en;

  assign wr_ok    = wr_en_i && unlock_i;
  assign ctrl_hit = (addr_i == ADDR_W'(CTRL_ADDR));

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_dec
    localparam fld_t MASK = fld_t'((1 << fld_bits(i)) - 1);
    assign hit[i]      = (addr_i == ADDR_W'(FIELD_BASE + FIELD_STRIDE * i));
    assign ld_o[i]     = wr_ok && hit[i];
    assign ld_val_o[i] = fld_t'(wdata_i) & MASK;
  end

  always_comb begin
    stop_en = wr_ok && ctrl_hit;
    stop_d  = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
    end else if (stop_en) begin
      stop_q <= stop_d;
    end
  end

  assign stop_o = stop_q;

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) rdata_o = DATA_W'(stop_q);
    for (int i = 0; i < NUM_FLD; i++) begin
      if (hit[i]) rdata_o = DATA_W'(fld_i[i]);
    end
  end
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int FIELD_BASE   = 'h40,
  parameter int FIELD_STRIDE = 4,
  parameter int CTRL_ADDR    = 'h20,
  parameter int YEAR_TOP     = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              unlock_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  fld_vec_t           fld_q;
  fld_vec_t           ld_val;
  logic [NUM_FLD-1:0] ld;
  logic [NUM_FLD-1:0] inc;
  logic [NUM_FLD-1:0] wrap;
  logic               stop;
  logic               tick_ok;
  fld_t               mlen;

  cal_bus_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_BASE(FIELD_BASE),
    .FIELD_STRIDE(FIELD_STRIDE), .CTRL_ADDR(CTRL_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .fld_i(fld_q), .ld_o(ld),
    .ld_val_o(ld_val), .stop_o(stop), .rdata_o(rdata_o)
  );

  cal_month_len #(.W(FLD_W)) mlen_i (
    .month_i(fld_q[IX_MONTH]), .year_i(fld_q[IX_YEAR]), .days_o(mlen)
  );

  // a seconds write takes the cycle: its tick is dropped (R10)
  assign tick_ok = tick_i && !stop && !ld[IX_SEC];

  always_comb begin
    inc           = '0;
    inc[IX_SEC]   = tick_ok;
    inc[IX_MIN]   = wrap[IX_SEC];
    inc[IX_HOUR]  = wrap[IX_MIN];
    inc[IX_WDAY]  = wrap[IX_HOUR];
    inc[IX_MDAY]  = wrap[IX_HOUR];
    inc[IX_MONTH] = wrap[IX_MDAY];
    inc[IX_YEAR]  = wrap[IX_MONTH];
  end

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    localparam fld_t LO = fld_lo(i);
    localparam fld_t HI = fld_hi(i, YEAR_TOP);
    fld_t hi_sel;
    if (i == IX_MDAY) begin : g_var_top
      assign hi_sel = mlen;
    end else begin : g_fix_top
      assign hi_sel = HI;
    end

    fld_t q;
    logic w;
    cal_wrap_cnt #(.W(FLD_W), .RST_VAL(LO)) cnt_i (
      .clk(clk), .rst_n(rst_n), .inc_i(inc[i]), .ld_i(ld[i]),
      .ld_val_i(ld_val[i]), .lo_i(LO), .hi_i(hi_sel),
      .q_o(q), .wrap_o(w)
    );
    assign fld_q[i] = q;
    assign wrap[i]  = w;
  end
endmodule

// File: rtl/cal_time_counter_chk.sv
module cal_time_counter_chk
  import cal_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int FIELD_BASE   = 'h40,
  parameter int FIELD_STRIDE = 4,
  parameter int YEAR_TOP     = 99
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              unlock_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input fld_vec_t          fld,
  input logic              stop
);
  logic wr_any;
  logic sec_hit;
  logic adv;
  logic midnight;
  logic new_year;

  assign wr_any   = wr_en_i && unlock_i;
  assign sec_hit  = (addr_i == ADDR_W'(FIELD_BASE + FIELD_STRIDE * IX_SEC));
  assign adv      = tick_i && !stop && !wr_en_i;
  assign midnight = (fld[IX_HOUR] == fld_t'(23)) && (fld[IX_MIN] == fld_t'(59)) &&
                    (fld[IX_SEC] == fld_t'(59));
  assign new_year = midnight && (fld[IX_MDAY] == fld_t'(31)) &&
                    (fld[IX_MONTH] == fld_t'(12)) && (fld[IX_YEAR] == fld_t'(YEAR_TOP));

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && (fld[IX_SEC] < fld_t'(59)) |=> fld[IX_SEC] == fld_t'($past(fld[IX_SEC]) + 1'b1));

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && (fld[IX_SEC] == fld_t'(59)) |=> fld[IX_SEC] == '0);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_en_i |=> $stable(fld) && $stable(stop));

  assert_midnight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && midnight |=> (fld[IX_HOUR] == '0) &&
      (fld[IX_WDAY] == (($past(fld[IX_WDAY]) >= fld_t'(6)) ? fld_t'(0)
                                                          : fld_t'($past(fld[IX_WDAY]) + 1'b1))));

  assert_year_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv && new_year |=> (fld[IX_YEAR] == '0) && (fld[IX_MONTH] == fld_t'(1)) &&
                        (fld[IX_MDAY] == fld_t'(1)));

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !wr_en_i |=> $stable(fld));

  assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !unlock_i && !tick_i |=> $stable(fld) && $stable(stop));

  assert_sec_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && sec_hit |=> (fld[IX_SEC] == {1'b0, $past(wdata_i[5:0])}) && $stable(fld[IX_MIN]));
endmodule

bind cal_time_counter cal_time_counter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_BASE(FIELD_BASE),
  .FIELD_STRIDE(FIELD_STRIDE), .YEAR_TOP(YEAR_TOP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .unlock_i(unlock_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .fld(fld_q), .stop(stop)
);

// File: tb/cal_time_counter_tb_top.sv
module cal_time_counter_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       unlock;
  logic       wr_en;
  logic [7:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;

  int  n_chk;
  int  n_fail;
  bit  done;

  cal_time_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .unlock_i(unlock),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {req, start y,mo,d,wd,h,mi,s, expected y,mo,d,wd,h,mi,s} after one tick
  localparam int NV = 15;
  localparam logic [101:0] VEC [NV] = '{
    {4'd3,  7'd5, 7'd3, 7'd10,7'd2,7'd8, 7'd30,7'd15, 7'd5, 7'd3, 7'd10,7'd2,7'd8, 7'd30,7'd16}, // R3
    {4'd3,  7'd5, 7'd3, 7'd10,7'd2,7'd8, 7'd30,7'd59, 7'd5, 7'd3, 7'd10,7'd2,7'd8, 7'd31,7'd0 }, // R3
    {4'd3,  7'd5, 7'd3, 7'd10,7'd2,7'd8, 7'd59,7'd59, 7'd5, 7'd3, 7'd10,7'd2,7'd9, 7'd0, 7'd0 }, // R3
    {4'd4,  7'd5, 7'd3, 7'd10,7'd6,7'd23,7'd59,7'd59, 7'd5, 7'd3, 7'd11,7'd0,7'd0, 7'd0, 7'd0 }, // R4
    {4'd5,  7'd5, 7'd4, 7'd30,7'd1,7'd23,7'd59,7'd59, 7'd5, 7'd5, 7'd1, 7'd2,7'd0, 7'd0, 7'd0 }, // R5
    {4'd5,  7'd5, 7'd1, 7'd31,7'd3,7'd23,7'd59,7'd59, 7'd5, 7'd2, 7'd1, 7'd4,7'd0, 7'd0, 7'd0 }, // R5
    {4'd5,  7'd5, 7'd4, 7'd29,7'd3,7'd23,7'd59,7'd59, 7'd5, 7'd4, 7'd30,7'd4,7'd0, 7'd0, 7'd0 }, // R5
    {4'd5,  7'd12,7'd11,7'd30,7'd2,7'd23,7'd59,7'd59, 7'd12,7'd12,7'd1, 7'd3,7'd0, 7'd0, 7'd0 }, // R5
    {4'd6,  7'd8, 7'd2, 7'd28,7'd0,7'd23,7'd59,7'd59, 7'd8, 7'd2, 7'd29,7'd1,7'd0, 7'd0, 7'd0 }, // R6
    {4'd6,  7'd8, 7'd2, 7'd29,7'd1,7'd23,7'd59,7'd59, 7'd8, 7'd3, 7'd1, 7'd2,7'd0, 7'd0, 7'd0 }, // R6
    {4'd6,  7'd0, 7'd2, 7'd28,7'd4,7'd23,7'd59,7'd59, 7'd0, 7'd3, 7'd1, 7'd5,7'd0, 7'd0, 7'd0 }, // R6
    {4'd6,  7'd7, 7'd2, 7'd28,7'd4,7'd23,7'd59,7'd59, 7'd7, 7'd3, 7'd1, 7'd5,7'd0, 7'd0, 7'd0 }, // R6
    {4'd6,  7'd96,7'd2, 7'd28,7'd2,7'd23,7'd59,7'd59, 7'd96,7'd2, 7'd29,7'd3,7'd0, 7'd0, 7'd0 }, // R6
    {4'd7,  7'd23,7'd12,7'd31,7'd5,7'd23,7'd59,7'd59, 7'd24,7'd1, 7'd1, 7'd6,7'd0, 7'd0, 7'd0 }, // R7
    {4'd7,  7'd99,7'd12,7'd31,7'd6,7'd23,7'd59,7'd59, 7'd0, 7'd1, 7'd1, 7'd0,7'd0, 7'd0, 7'd0 }  // R7
  };

  localparam logic [7:0] A_CTRL = 8'h20;
  function automatic logic [7:0] fa(input int k);
    return 8'h40 + 8'(4 * k);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic check(input int req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic ul);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; unlock = ul;
    @(negedge clk);
    wr_en = 1'b0; unlock = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] mn;
    n_chk = 0; n_fail = 0; done = 1'b0;
    tick = 0; unlock = 0; wr_en = 0; addr = 8'h00; wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    bus_rd(fa(0), v); check(1, "reset year", v, 8'd0);
    bus_rd(fa(1), v); check(1, "reset month", v, 8'd1);
    bus_rd(fa(2), v); check(1, "reset mday", v, 8'd1);
    bus_rd(fa(3), v); check(1, "reset wday", v, 8'd0);
    bus_rd(fa(4), v); check(1, "reset hour", v, 8'd0);
    bus_rd(fa(5), v); check(1, "reset min", v, 8'd0);
    bus_rd(fa(6), v); check(1, "reset sec", v, 8'd0);
    bus_rd(A_CTRL, v); check(1, "reset freeze", v, 8'd0);

    // R2: unmapped addresses read zero
    bus_rd(8'h00, v); check(2, "unmapped 0x00", v, 8'd0);
    bus_rd(8'h3C, v); check(2, "unmapped 0x3C", v, 8'd0);
    bus_rd(8'h5C, v); check(2, "unmapped 0x5C", v, 8'd0);

    // table walk: load under freeze, release, one tick, read all fields
    for (int n = 0; n < NV; n++) begin
      bus_wr(A_CTRL, 8'h01, 1'b1);
      for (int k = 0; k < 7; k++) bus_wr(fa(k), {1'b0, VEC[n][97-7*k -: 7]}, 1'b1);
      bus_wr(A_CTRL, 8'h00, 1'b1);
      pulse_tick();
      for (int k = 0; k < 7; k++) begin
        bus_rd(fa(k), v);
        check(int'(VEC[n][101:98]), $sformatf("vector %0d field %0d", n, k),
              v, {1'b0, VEC[n][48-7*k -: 7]});
      end
    end

    // R8: freeze holds fields, release resumes
    bus_wr(A_CTRL, 8'h01, 1'b1);
    bus_wr(fa(6), 8'd20, 1'b1);
    bus_wr(fa(5), 8'd7, 1'b1);
    bus_rd(A_CTRL, v); check(8, "freeze readback", v, 8'd1);
    pulse_tick(); pulse_tick(); pulse_tick();
    bus_rd(fa(6), v); check(8, "sec held while frozen", v, 8'd20);
    bus_wr(A_CTRL, 8'h00, 1'b1);
    pulse_tick();
    bus_rd(fa(6), v); check(8, "sec after release", v, 8'd21);

    // R9: locked write ignored, truncation to field width
    bus_wr(fa(6), 8'd33, 1'b0);
    bus_rd(fa(6), v); check(9, "locked sec write ignored", v, 8'd21);
    bus_wr(fa(0), 8'd44, 1'b0);
    bus_rd(fa(0), v); check(9, "locked year write ignored", v, 8'd0);
    bus_wr(fa(3), 8'hFD, 1'b1);
    bus_rd(fa(3), v); check(9, "wday truncated to 3 bits", v, 8'd5);
    bus_wr(fa(1), 8'hF7, 1'b1);
    bus_rd(fa(1), v); check(9, "month truncated to 4 bits", v, 8'd7);

    // R10: tick coinciding with a seconds write is dropped
    bus_wr(fa(6), 8'd59, 1'b1);
    bus_rd(fa(5), mn);
    @(negedge clk);
    addr = fa(6); wdata = 8'd40; wr_en = 1'b1; unlock = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; unlock = 1'b0; tick = 1'b0;
    bus_rd(fa(6), v); check(10, "sec takes written value", v, 8'd40);
    bus_rd(fa(5), v); check(10, "min unchanged", v, mn);
    pulse_tick();
    bus_rd(fa(6), v); check(10, "sec counts from written value", v, 8'd41);

    // R3: no tick, no change
    repeat (5) @(negedge clk);
    bus_rd(fa(6), v); check(3, "sec idle without tick", v, 8'd41);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule